// File: doc/BRIEF.md
# SDRAM Power-Up, Access and Refresh Sequencer

This block sits on the controller side of a two-bank, 16-bit single-data-rate SDRAM. After reset it brings the memory up in a fixed order: a long quiet period, a precharge of both banks, a train of auto-refresh commands, and a mode register write. Once that is done it serves one host request at a time. A request carries an address and a write flag and completes with a valid/ready handshake. The block turns each request into a row activate followed by a single read or write. That read or write always carries the auto-precharge flag, so every row is closed again once the access completes.

A free-running interval timer paces auto-refresh so that the whole array is refreshed at 4096 rows per 64 ms. A refresh that falls due takes precedence over the next host request. It waits only for the access already in flight to finish its precharge recovery. Every spacing between commands is a whole number of clock cycles. Each one is derived at elaboration time from a nanosecond figure and the clock frequency, rounded up. The data bus is handled elsewhere; this block only drives the command, address and bank lines.

Top module: `sdram_seq`

## Requirements
- R1: While reset is asserted, and at all times after it, CKE is high. During reset the command lines carry NOP and host_ready is low.
- R2: Commands are coded on {CS#,RAS#,CAS#,WE#} as follows: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, mode set 0000. No other code is ever driven.
- R3: The first command after reset is a precharge with address bit 10 high, meaning all banks. It comes no earlier than INIT_US × CLK_MHZ cycles after reset release. It is followed by at least INIT_REFS auto-refreshes. The first refresh is at least tRP after the precharge and each later one is at least tRC after the one before it.
- R4: The mode set follows the last power-up refresh by at least tRC. Its address carries CAS_LAT in bits 6:4, 0 in bit 3 (sequential) and 000 in bits 2:0 (burst of one). Bits 10:7 and the bank line are 0. The next command comes at least MRD_CYC cycles later.
- R5: host_ready stays low until the mode set has been issued, and whenever a refresh is due or a command spacing is still running. A request held valid while ready is low causes no activate. Only one request is taken per handshake.
- R6: host_addr is laid out as {bank[19], row[18:8], column[7:0]}. An accepted request produces an activate with the row on sd_addr and the bank on sd_ba. At least tRCD later a read follows (write flag 0) or a write follows (write flag 1), on the same bank, with the column in sd_addr[7:0] and sd_addr[10] = 1 for auto-precharge.
- R7: The command after a read is at least 1+tRP after that read, and the command after a write is at least tWR+tRP after that write. An activate or refresh comes at least max(tRC, tRAS+tRP) after the previous activate.
- R8: Once the mode set is done, auto-refresh is issued every REFI = floor(REF_MS·1000·CLK_MHZ/REF_ROWS) cycles. It is delayed by at most one access plus tRC and the mode-set spacing, and each refresh is followed by a gap of at least tRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request present |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | {bank, row, column} |
| host_ready | output | 1 | Request accepted on this cycle when valid |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select (0 = first bank) |
| sd_addr | output | 11 | Multiplexed row/column/mode address |

## Verification
The assertions check the following on every cycle:
- CKE stays high.
- Ready only ever coincides with a NOP.
- Every activate traces back to a handshake on the previous edge.
- Reads and writes carry the auto-precharge bit and respect tRCD.
- Refreshes keep tRC apart and never fall overdue once the mode set has been issued.

Only the bench scenarios can show the rest:
- The full power-up order and the mode word.
- That the row, bank, column and direction of each command match the request that caused it.
- The recovery gaps after reads and writes.
- That a request held high during power-up or a pending refresh is taken exactly once.

// File: rtl/sdram_seq.sv
module sdram_seq #(
  parameter int CLK_MHZ   = 100,
  parameter int INIT_US   = 200,
  parameter int INIT_REFS = 8,
  parameter int CAS_LAT   = 2,
  parameter int RCD_NS    = 30,
  parameter int RP_NS     = 30,
  parameter int RC_NS     = 100,
  parameter int RAS_NS    = 60,
  parameter int WR_NS     = 15,
  parameter int MRD_CYC   = 2,
  parameter int REF_ROWS  = 4096,
  parameter int REF_MS    = 64,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_valid,
  input  logic                       host_write,
  input  logic [ROW_W+COL_W:0]       host_addr,
  output logic                       host_ready,
  output logic                       sd_cke,
  output logic                       sd_cs_n,
  output logic                       sd_ras_n,
  output logic                       sd_cas_n,
  output logic                       sd_we_n,
  output logic                       sd_ba,
  output logic [ROW_W-1:0]           sd_addr
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  localparam int ADDR_W   = ROW_W + COL_W + 1;
  localparam int AP_BIT   = 10;
  localparam int T_RCD    = ns2cyc(RCD_NS);
  localparam int T_RP     = ns2cyc(RP_NS);
  localparam int T_RC     = ns2cyc(RC_NS);
  localparam int T_RAS    = ns2cyc(RAS_NS);
  localparam int T_WR     = ns2cyc(WR_NS);
  localparam int T_MRD    = (MRD_CYC < 1) ? 1 : MRD_CYC;
  localparam int INIT_CYC = INIT_US * CLK_MHZ;
  localparam int REFI     = (REF_MS * 1000 * CLK_MHZ) / REF_ROWS;
  localparam int DONE_RD  = max3(T_RC - T_RCD, 1 + T_RP, T_RAS + T_RP - T_RCD);
  localparam int DONE_WR  = max3(T_RC - T_RCD, T_WR + T_RP, T_RAS + T_RP - T_RCD);
  localparam int WAIT_W   = $clog2(max3(INIT_CYC, T_RC, DONE_WR) + 1);
  localparam int REF_W    = $clog2(REFI + 1);
  localparam int REFN_W   = $clog2(INIT_REFS + 1);

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {ST_POWER, ST_IREF, ST_MRS, ST_IDLE, ST_RW} state_t;

  state_t             state;
  logic [3:0]         cmd_q;
  logic [ROW_W-1:0]   addr_q;
  logic               ba_q;
  logic [WAIT_W-1:0]  wcnt;
  logic [REFN_W-1:0]  irefs;
  logic [REF_W-1:0]   ref_tmr;
  logic               ref_pend;
  logic               run;
  logic               req_wr;
  logic [COL_W-1:0]   req_col;
  logic [ROW_W-1:0]   rw_addr, mode_word, pall_addr;

  assign sd_cke = 1'b1;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr = addr_q;
  assign sd_ba = ba_q;
  assign host_ready = (state == ST_IDLE) && (wcnt == '0) && !ref_pend;

  always_comb begin
    rw_addr = '0;
    rw_addr[COL_W-1:0] = req_col;
    rw_addr[AP_BIT] = 1'b1;
    mode_word = '0;
    mode_word[6:4] = 3'(CAS_LAT);
    pall_addr = '0;
    pall_addr[AP_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_POWER;
      wcnt     <= WAIT_W'(INIT_CYC - 1);
      cmd_q    <= CMD_NOP;
      addr_q   <= '0;
      ba_q     <= 1'b0;
      irefs    <= '0;
      ref_tmr  <= '0;
      ref_pend <= 1'b0;
      run      <= 1'b0;
      req_wr   <= 1'b0;
      req_col  <= '0;
    end else begin
      cmd_q <= CMD_NOP;
      if (wcnt != '0) begin
        wcnt <= wcnt - 1'b1;
      end else begin
        case (state)
          ST_POWER: begin
            cmd_q  <= CMD_PRE;
            addr_q <= pall_addr;
            ba_q   <= 1'b0;
            wcnt   <= WAIT_W'(T_RP - 1);
            irefs  <= REFN_W'(INIT_REFS);
            state  <= ST_IREF;
          end
          ST_IREF: begin
            cmd_q <= CMD_REF;
            wcnt  <= WAIT_W'(T_RC - 1);
            irefs <= irefs - 1'b1;
            if (irefs <= REFN_W'(1)) state <= ST_MRS;
          end
          ST_MRS: begin
            cmd_q   <= CMD_MRS;
            addr_q  <= mode_word;
            ba_q    <= 1'b0;
            wcnt    <= WAIT_W'(T_MRD - 1);
            run     <= 1'b1;
            ref_tmr <= REF_W'(REFI - 1);
            state   <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd_q    <= CMD_REF;
              wcnt     <= WAIT_W'(T_RC - 1);
              ref_pend <= 1'b0;
            end else if (host_valid) begin
              cmd_q   <= CMD_ACT;
              addr_q  <= host_addr[COL_W +: ROW_W];
              ba_q    <= host_addr[ADDR_W-1];
              req_wr  <= host_write;
              req_col <= host_addr[COL_W-1:0];
              wcnt    <= WAIT_W'(T_RCD - 1);
              state   <= ST_RW;
            end
          end
          default: begin
            cmd_q  <= req_wr ? CMD_WR : CMD_RD;
            addr_q <= rw_addr;
            wcnt   <= req_wr ? WAIT_W'(DONE_WR - 1) : WAIT_W'(DONE_RD - 1);
            state  <= ST_IDLE;
          end
        endcase
      end
      if (run) begin
        if (ref_tmr == '0) begin
          ref_tmr  <= REF_W'(REFI - 1);
          ref_pend <= 1'b1;
        end else begin
          ref_tmr <= ref_tmr - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int T_RC      = 10,
  parameter int T_RCD     = 3,
  parameter int REF_LIMIT = 1600
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_valid,
  input logic        host_ready,
  input logic        sd_cke,
  input logic        sd_cs_n,
  input logic        sd_ras_n,
  input logic        sd_cas_n,
  input logic        sd_we_n,
  input logic        sd_ba,
  input logic [10:0] sd_addr
);
  localparam int CW = $clog2(REF_LIMIT + 2) + 1;

  logic [3:0]    cmd;
  logic [CW-1:0] since_ref, since_act;
  logic          seen_mrs;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref <= '1;
      since_act <= '1;
      seen_mrs  <= 1'b0;
    end else begin
      if (cmd == 4'b0001) since_ref <= '0;
      else if (since_ref != '1) since_ref <= since_ref + 1'b1;
      if (cmd == 4'b0011) since_act <= '0;
      else if (since_act != '1) since_act <= since_act + 1'b1;
      if (cmd == 4'b0000) seen_mrs <= 1'b1;
    end
  end

  AST_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) sd_cke); // R1
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> cmd == 4'b0111); // R5
  AST_ACT_FROM_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0011 |-> $past(host_valid && host_ready)); // R6
  AST_RW_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0101 || cmd == 4'b0100) |-> sd_addr[10]); // R6
  AST_RW_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0101 || cmd == 4'b0100) |-> since_act >= CW'(T_RCD - 1)); // R6
  AST_MRS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0000 |-> (sd_addr[10:7] == 4'b0 && !sd_ba)); // R4
  AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0001 |-> since_ref >= CW'(T_RC - 1)); // R3
  AST_REF_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    seen_mrs |-> since_ref <= CW'(REF_LIMIT)); // R8
endmodule

bind sdram_seq sdram_seq_chk #(
  .T_RC(T_RC),
  .T_RCD(T_RCD),
  .REF_LIMIT(REFI + T_RC + T_MRD + T_RCD + DONE_WR + 2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
  .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
);

// File: tb/sdram_seq_test.sv
`timescale 1ns/1ps
module sdram_seq_test;
  localparam int CLK_MHZ = 100;
  localparam int INIT_CYC = 200 * CLK_MHZ;
  localparam int INIT_REFS = 8;
  localparam int CAS_LAT = 2;
  localparam int T_RCD = (30 * CLK_MHZ + 999) / 1000;
  localparam int T_RP  = (30 * CLK_MHZ + 999) / 1000;
  localparam int T_RC  = (100 * CLK_MHZ + 999) / 1000;
  localparam int T_RAS = (60 * CLK_MHZ + 999) / 1000;
  localparam int T_WR  = (15 * CLK_MHZ + 999) / 1000;
  localparam int T_MRD = 2;
  localparam int REFI  = (64 * 1000 * CLK_MHZ) / 4096;
  localparam int REF_MAX = REFI + 2 * T_RC + T_RAS + T_RP + T_WR + T_MRD + 4;

  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [19:0] host_addr = '0;
  logic host_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba;
  logic [10:0] sd_addr;

  always #10 clk = ~clk;

  sdram_seq uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_ready(host_ready), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  int n_vec = 0, n_bad = 0;
  int cyc = 0, n_cmd = 0, init_refs = 0, n_ref_run = 0, n_acc = 0, n_act = 0;
  int last_cyc = 0, last_act = 0, last_ref = 0;
  logic [3:0] last_cmd = NOP;
  bit seen_mrs = 0, pend_req = 0, exp_wr = 0, ready_seen = 0, done = 0;
  logic [19:0] exp_addr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int mode_word();
    return CAS_LAT << 4;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    logic [3:0] c;
    int gap;
    cyc++;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    gap = cyc - last_cyc;
    if (host_ready && !ready_seen) begin
      ready_seen = 1;
      chk(seen_mrs, "R5 ready before mode set", 0, 1);
    end
    if (c != NOP) begin
      if (seen_mrs && (c == ACT || c == REF)) begin
        if (last_cmd == MRS) chk(gap >= T_MRD, "R4 mode-set spacing", gap, T_MRD);
        if (last_cmd == REF) chk(gap >= T_RC, "R8 refresh recovery", gap, T_RC);
        if (last_cmd == RD) chk(gap >= 1 + T_RP, "R7 read recovery", gap, 1 + T_RP);
        if (last_cmd == WR) chk(gap >= T_WR + T_RP, "R7 write recovery", gap, T_WR + T_RP);
        if (last_cmd == RD || last_cmd == WR)
          chk(cyc - last_act >= max2(T_RC, T_RAS + T_RP), "R7 activate spacing",
              cyc - last_act, max2(T_RC, T_RAS + T_RP));
      end
      case (c)
        PRE: chk(n_cmd == 0 && cyc >= INIT_CYC && sd_addr[10], "R3 precharge-all", cyc, INIT_CYC);
        REF: begin
          if (!seen_mrs) begin
            chk(gap >= ((last_cmd == PRE) ? T_RP : T_RC) && n_cmd >= 1, "R3 power-up refresh",
                gap, (last_cmd == PRE) ? T_RP : T_RC);
            init_refs++;
          end else begin
            chk(cyc - last_ref <= REF_MAX, "R8 refresh interval", cyc - last_ref, REF_MAX);
            n_ref_run++;
          end
          last_ref = cyc;
        end
        MRS: begin
          chk(init_refs >= INIT_REFS, "R3 refresh count", init_refs, INIT_REFS);
          chk(int'(sd_addr) == mode_word() && !sd_ba && gap >= T_RC, "R4 mode word",
              int'(sd_addr), mode_word());
          seen_mrs = 1;
        end
        ACT: begin
          n_act++;
          chk(seen_mrs && pend_req, "R5 activate without request", int'(pend_req), 1);
          chk({sd_ba, sd_addr} == exp_addr[19:8], "R6 row/bank", int'({sd_ba, sd_addr}),
              int'(exp_addr[19:8]));
          last_act = cyc;
        end
        RD, WR: begin
          chk(last_cmd == ACT && gap >= T_RCD, "R6 column after tRCD", gap, T_RCD);
          chk((c == WR) == exp_wr, "R6 direction", int'(c == WR), int'(exp_wr));
          chk(sd_addr[7:0] == exp_addr[7:0] && sd_addr[10] && sd_ba == exp_addr[19],
              "R6 column/auto-precharge", int'({sd_ba, sd_addr}),
              int'({exp_addr[19], 3'b100, exp_addr[7:0]}));
          pend_req = 0;
        end
        default: chk(0, "R2 unknown command", int'(c), int'(NOP));
      endcase
      n_cmd++;
      last_cmd = c;
      last_cyc = cyc;
    end
    if (host_valid && host_ready) begin
      chk(!pend_req, "R5 second request taken", int'(pend_req), 0);
      pend_req = 1;
      exp_addr = host_addr;
      exp_wr = host_write;
      n_acc++;
    end
  end

  task automatic do_req(input logic [19:0] a, input bit w);
    @(posedge clk); #1;
    host_valid = 1'b1; host_addr = a; host_write = w;
    forever begin
      @(negedge clk);
      if (host_ready) break;
    end
    @(posedge clk); #1;
    host_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(sd_cke && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP && !host_ready,
        "R1 reset state", int'({sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, host_ready}), 6'b101110);
    @(posedge clk); #1;
    rst_n = 1'b1;
    chk(sd_cke, "R1 cke after reset", int'(sd_cke), 1);
    // R5: request held valid across the whole power-up
    do_req(20'hFFFFF, 1'b1);
    do_req(20'h00000, 1'b0);
    do_req({1'b1, 11'h7FF, 8'h00}, 1'b0);
    do_req({1'b0, 11'h000, 8'hFF}, 1'b1);
    void'($urandom(32'd4242));
    for (int i = 0; i < 300; i++) begin
      int idle;
      idle = (i % 7 == 0) ? 0 : int'($urandom % 25);
      repeat (idle) @(posedge clk);
      do_req(20'($urandom), 1'($urandom));
    end
    repeat (REFI + 100) @(negedge clk);
    chk(!pend_req && n_act == n_acc, "R6 every request served once", n_act, n_acc);
    chk(n_ref_run >= 3, "R8 periodic refresh seen", n_ref_run, 3);
    chk(sd_cke, "R1 cke at end", int'(sd_cke), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule